// File: doc/BRIEF.md
# Two-Phase Processor Data Bus Interface

This block is the data side of a small processor's bus port. The port runs from one clock that is split into two mutually exclusive phase enables. In the first phase of each bus cycle, an outbound holding register captures the internal result bus. In the second phase, two inbound registers capture the byte that is on the external data bus. One is the general input latch. The other is the predecode register that feeds instruction decode.

The external bus is modelled as three separate nets: input pins, output pins and an output enable. The block drives the pins only during the second phase of a write cycle. Every bus cycle is either a read or a write; there is no idle cycle. The inbound registers load on every second phase without any condition. On a write cycle they therefore capture the byte the block is driving itself, and the input pins are ignored. This stale byte is harmless, because every instruction starts with an opcode fetch read, and that read replaces the predecode contents before decode uses them.

Top module: `dbus_iface`

## Requirements
- R1: While rst_n is low, pin_oe is 0. A clock edge with rst_n low clears pin_dout, int_data and opcode_pre to 0x00.
- R2: A clock edge with phi1_en high loads result_bus into the outbound register. An edge with phi1_en low leaves it unchanged.
- R3: A clock edge with phi2_en high loads the bus value into both int_data and opcode_pre. An edge with phi2_en low leaves both unchanged, so the two registers always hold the same value.
- R4: pin_oe is 1 exactly when rst_n is high, phi2_en is high and rw is 0 (rw = 1 marks a read, rw = 0 marks a write). pin_oe is never 1 in the first phase.
- R5: pin_dout always shows the outbound register. During a write, the pins therefore carry the byte loaded in the preceding first phase, even if result_bus changes during the second phase.
- R6: On a write cycle, the second-phase capture takes the driven byte (the outbound register) and ignores pin_din.
- R7: On a read cycle, the second-phase capture takes pin_din. A read that follows one or more writes therefore replaces the stale write-back byte in opcode_pre with the fetched opcode.
- R8: phi1_en and phi2_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi1_en | input | 1 | First-phase enable |
| phi2_en | input | 1 | Second-phase enable |
| rw | input | 1 | Cycle type: 1 read, 0 write |
| result_bus | input | DATA_W | Internal result bus |
| pin_din | input | DATA_W | Value sensed on external data pins |
| pin_dout | output | DATA_W | Value offered to external data pins |
| pin_oe | output | 1 | External pin drive enable |
| int_data | output | DATA_W | Input data latch contents |
| opcode_pre | output | DATA_W | Predecode register contents |

## Verification
The hardest situation to reach is the self-capture on writes. On a write, the inbound registers must take the driven byte while pin_din carries a conflicting value, and the next read must then replace that stale byte. The stimulus sweeps all 256 byte values. Each iteration runs a write with pin_din set to the complement of the result, then a second write straight after it, then a read with an unrelated opcode pattern. It also changes result_bus during the second phase to show that the driven byte comes from the earlier first phase. One reset is applied in the middle of a write's second phase to check that the pin drive is released at once.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
   typedef enum logic {
      CYC_WRITE = 1'b0,
      CYC_READ  = 1'b1
   } cyc_e;

   function automatic logic is_write(input logic rw_bit);
      return cyc_e'(rw_bit) == CYC_WRITE;
   endfunction
endpackage

// File: rtl/dbus_phase_reg.sv
module dbus_phase_reg #(
   parameter int W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dbus_phase_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (en) begin
         q <= d;
      end
   end
endmodule

// File: rtl/dbus_drive.sv
module dbus_drive
   import dbus_pkg::*;
#(
   parameter int W        = 8,
   parameter bit LOOPBACK = 1'b1
) (
   input  logic         rst_n,
   input  logic         rw,
   input  logic         phi2_en,
   input  logic [W-1:0] out_q,
   input  logic [W-1:0] pin_din,
   output logic         pin_oe,
   output logic [W-1:0] pin_dout,
   output logic [W-1:0] bus_val
);
   logic drive;

   always_comb begin
      drive    = rst_n & phi2_en & is_write(rw);
      pin_oe   = drive;
      pin_dout = out_q;
   end

   generate
      if (LOOPBACK) begin : g_loop
         // separate nets: the driven byte is echoed internally
         always_comb bus_val = drive ? out_q : pin_din;
      end else begin : g_pins
         // an external resolver already folds the drive into pin_din
         always_comb bus_val = pin_din;
      end
   endgenerate
endmodule

// File: rtl/dbus_iface.sv
module dbus_iface #(
   parameter int DATA_W   = 8,
   parameter bit LOOPBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi1_en,
   input  logic              phi2_en,
   input  logic              rw,
   input  logic [DATA_W-1:0] result_bus,
   input  logic [DATA_W-1:0] pin_din,
   output logic [DATA_W-1:0] pin_dout,
   output logic              pin_oe,
   output logic [DATA_W-1:0] int_data,
   output logic [DATA_W-1:0] opcode_pre
);
   localparam int NUM_IN = 2;

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_w
         $error("dbus_iface: DATA_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] out_q;
   logic [DATA_W-1:0] bus_val;
   logic [DATA_W-1:0] in_q [NUM_IN];

   dbus_phase_reg #(.W(DATA_W)) u_out_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (phi1_en),
      .d    (result_bus),
      .q    (out_q)
   );

   dbus_drive #(.W(DATA_W), .LOOPBACK(LOOPBACK)) u_drive (
      .rst_n   (rst_n),
      .rw      (rw),
      .phi2_en (phi2_en),
      .out_q   (out_q),
      .pin_din (pin_din),
      .pin_oe  (pin_oe),
      .pin_dout(pin_dout),
      .bus_val (bus_val)
   );

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_in
         dbus_phase_reg #(.W(DATA_W)) u_in_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (phi2_en),
            .d    (bus_val),
            .q    (in_q[i])
         );
      end
   endgenerate

   assign int_data   = in_q[0];
   assign opcode_pre = in_q[1];
endmodule

// File: rtl/dbus_iface_chk.sv
module dbus_iface_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              phi1_en,
   input logic              phi2_en,
   input logic              rw,
   input logic [DATA_W-1:0] result_bus,
   input logic [DATA_W-1:0] pin_din,
   input logic [DATA_W-1:0] pin_dout,
   input logic              pin_oe,
   input logic [DATA_W-1:0] int_data,
   input logic [DATA_W-1:0] opcode_pre
);
   a_r8_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(phi1_en && phi2_en));

   a_r2_out_load: assert property (@(posedge clk) disable iff (!rst_n)
      phi1_en |=> pin_dout == $past(result_bus));

   a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !phi1_en |=> $stable(pin_dout));

   a_r3_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2_en |=> $stable(int_data) && $stable(opcode_pre));

   a_r3_in_agree: assert property (@(posedge clk) disable iff (!rst_n)
      int_data == opcode_pre);

   a_r4_no_drive_phi1: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> !phi1_en && !rw);

   a_r6_loopback: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2_en && !rw) |=> int_data == $past(pin_dout));

   a_r7_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2_en && rw) |=> opcode_pre == $past(pin_din));
endmodule

bind dbus_iface dbus_iface_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_dbus_iface.sv
module test_dbus_iface;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       phi1_en, phi2_en, rw;
   logic [7:0] result_bus, pin_din;
   logic [7:0] pin_dout, int_data, opcode_pre;
   logic       pin_oe;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_in;

   always #2.5 clk = ~clk;

   dbus_iface i_dbus_iface (
      .clk(clk), .rst_n(rst_n), .phi1_en(phi1_en), .phi2_en(phi2_en),
      .rw(rw), .result_bus(result_bus), .pin_din(pin_din),
      .pin_dout(pin_dout), .pin_oe(pin_oe), .int_data(int_data),
      .opcode_pre(opcode_pre)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   // one bus cycle: a phi1 clock then a phi2 clock; rw 1 = read, 0 = write
   task automatic bus_cycle(input logic is_read, input logic [7:0] res, input logic [7:0] pins);
      phi1_en = 1'b1; phi2_en = 1'b0; rw = is_read;
      result_bus = res; pin_din = pins;
      #1 chk("R4 no drive in phi1", {7'b0, pin_oe}, 8'h00);
      @(negedge clk);
      chk("R2 phi1 load", pin_dout, res);
      chk("R3 hold before phi2", int_data, exp_in);
      phi1_en = 1'b0; phi2_en = 1'b1;
      result_bus = ~res;                      // must not disturb driven byte
      #1 chk("R4 oe in phi2", {7'b0, pin_oe}, {7'b0, ~is_read});
      chk("R5 driven byte from phi1", pin_dout, res);
      @(negedge clk);
      exp_in = is_read ? pins : res;
      if (is_read) chk("R7 read capture", opcode_pre, exp_in);
      else         chk("R6 write loopback", int_data, exp_in);
      chk("R3 both agree", opcode_pre, int_data);
      chk("R2 hold in phi2", pin_dout, res);
      phi2_en = 1'b0;
   endtask

   initial begin
      #20000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; phi1_en = 1'b0; phi2_en = 1'b0; rw = 1'b1;
      result_bus = 8'hA5; pin_din = 8'h3C;
      repeat (3) @(negedge clk);
      chk("R1 reset out", pin_dout, 8'h00);
      chk("R1 reset latch", int_data, 8'h00);
      chk("R1 reset predecode", opcode_pre, 8'h00);
      chk("R1 reset oe", {7'b0, pin_oe}, 8'h00);
      rst_n = 1'b1;
      exp_in = 8'h00;

      for (int v = 0; v < 256; v++) begin
         bus_cycle(1'b0, 8'(v), ~8'(v));          // read then write / write
         bus_cycle(1'b0, 8'(v + 37), 8'(v));      // back-to-back write
         bus_cycle(1'b1, 8'(v * 3), 8'(v) ^ 8'h5A); // opcode fetch
         chk("R7 stale predecode replaced", opcode_pre, 8'(v) ^ 8'h5A);
      end

      // reset during the drive phase of a write
      bus_cycle(1'b0, 8'hC3, 8'h11);
      phi2_en = 1'b1; rw = 1'b0; rst_n = 1'b0;
      #1 chk("R1 oe released in reset", {7'b0, pin_oe}, 8'h00);
      @(negedge clk);
      chk("R1 mid reset out", pin_dout, 8'h00);
      chk("R1 mid reset predecode", opcode_pre, 8'h00);
      phi2_en = 1'b0; rst_n = 1'b1; exp_in = 8'h00;
      bus_cycle(1'b1, 8'h77, 8'hE8);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule